// File: doc/BRIEF.md
# Multi-Chip Flash Address Region Decoder

This block takes a flat flash address and works out which of up to four attached serial flash devices it falls in, and where inside that device it lands. Two devices hang off bus A and two off bus B. Four programmable top-address values cut the address window into consecutive regions, always taken in the fixed order A1, A2, B1, B2. Each region runs from the top of the region before it (or from the window base, for the first one) up to, but not including, its own top. The decoder reports the chosen region as a one-hot select, as a bus bit and a chip-select bit, and as the device-local offset.

The same decoder serves both the start address of a command issued by software and the address of a memory-mapped read. A configuration bit says whether the incoming address already carries the window base or whether the block must add the base itself before comparing. A single-bus setting limits the decode to the two bus-A regions and ignores the bus-B tops. Addresses outside the populated regions are flagged and select nothing. The result is registered, with a valid strobe carried alongside.

Top module: `flash_region_decoder`

## Requirements
- R1: While and directly after reset, out_valid, out_sel, out_bus, out_cs, out_err and out_offset are all zero.
- R2: A request presented with in_valid high at a clock edge produces its result at that same edge, so it is visible for the whole following cycle; out_valid in each cycle equals in_valid sampled at the edge before.
- R3: The effective address is compared strictly below each top in the order A1, A2, B1, B2 and the first match wins; out_sel is one-hot with bit 0 = A1, bit 1 = A2, bit 2 = B1, bit 3 = B2; out_bus is 0 for bus A and 1 for bus B; out_cs is 0 for the first and 1 for the second device on a bus.
- R4: out_offset equals the effective address minus the lower bound of the selected region, where the lower bound of A1 is cfg_base and that of every later region is the top of the region before it; a region whose top equals the previous top is never selected.
- R5: With cfg_add_base = 1 the effective address is in_addr + cfg_base modulo 2^ADDR_W; with cfg_add_base = 0 it is in_addr unchanged.
- R6: An effective address below cfg_base, or at or above the top of the last active region, gives out_err = 1 with out_sel, out_bus, out_cs and out_offset all zero.
- R7: With cfg_single_bus = 1 only A1 and A2 are decoded, the B1 and B2 tops have no effect, out_sel bits 3 and 2 stay zero, and addresses at or above the A2 top are out of range.
- R8: When in_valid is low, out_sel, out_bus, out_cs, out_err and out_offset keep the values of the last accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W | Incoming flash or mapped-read address |
| cfg_base | input | ADDR_W | Window base address |
| cfg_add_base | input | 1 | 1: add cfg_base to in_addr before decode |
| cfg_single_bus | input | 1 | 1: decode only the two bus-A regions |
| cfg_top_a1 | input | ADDR_W | Top of region A1 (exclusive) |
| cfg_top_a2 | input | ADDR_W | Top of region A2 (exclusive) |
| cfg_top_b1 | input | ADDR_W | Top of region B1 (exclusive) |
| cfg_top_b2 | input | ADDR_W | Top of region B2 (exclusive) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_sel | output | 4 | One-hot region select (A1, A2, B1, B2 from bit 0) |
| out_bus | output | 1 | 0 = bus A, 1 = bus B |
| out_cs | output | 1 | Chip select within the bus |
| out_offset | output | ADDR_W | Device-local offset |
| out_err | output | 1 | Address outside every active region |

## Verification
The bench sweeps every address of a 12-bit window under an equal split, with and without base addition, in single-bus mode, and with an uneven split that contains an empty region. The exact boundary addresses matter most: a less-or-equal compare would hand each region's top address to the wrong device, and a wrong lower bound would shift every offset after the first region. Base addition is checked where the sum wraps below the base, which a design without the below-base test would accept as region A1 with a huge offset. Single-bus mode is driven with bus-B tops that would match, so a decoder that still looked at them would select B1 instead of flagging the address, and idle cycles with a changed address catch a result register that loads without a valid strobe.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  // Fixed architecture: two buses with two chip selects each.
  localparam int NUM_REGIONS = 4;
  localparam int REGION_IDX_W = $clog2(NUM_REGIONS);
  localparam int BUS_A_REGIONS = 2;

  typedef enum logic {
    BUS_A = 1'b0,
    BUS_B = 1'b1
  } fdec_bus_e;
endpackage

// File: rtl/fdec_addr_norm.sv
module fdec_addr_norm #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              add_base,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              below_base
);
  // Effective address wraps modulo 2^ADDR_W when the base is added.
  always_comb begin
    eff_addr   = add_base ? (addr + base) : addr;
    below_base = (eff_addr < base);
  end
endmodule

// File: rtl/fdec_region_cmp.sv
module fdec_region_cmp
  import fdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      eff_addr,
  input  logic [ADDR_W-1:0]      tops [NUM_REGIONS],
  input  logic                   single_bus,
  output logic [NUM_REGIONS-1:0] below_top
);
  // One strict less-than comparator per region; bus-B ones are gated off
  // in single-bus mode.
  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_cmp
    if (k < BUS_A_REGIONS) begin : g_bus_a
      assign below_top[k] = (eff_addr < tops[k]);
    end else begin : g_bus_b
      assign below_top[k] = !single_bus && (eff_addr < tops[k]);
    end
  end
endmodule

// File: rtl/fdec_select.sv
module fdec_select
  import fdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]       eff_addr,
  input  logic [ADDR_W-1:0]       base,
  input  logic [ADDR_W-1:0]       tops [NUM_REGIONS],
  input  logic [NUM_REGIONS-1:0]  below_top,
  input  logic                    below_base,
  output logic [NUM_REGIONS-1:0]  sel,
  output logic [REGION_IDX_W-1:0] idx,
  output logic                    err,
  output logic [ADDR_W-1:0]       offset
);
  logic              found;
  logic [ADDR_W-1:0] lower;

  // Lowest-numbered match wins: scan from the top down so the last write
  // is the first region in A1, A2, B1, B2 order.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
      if (below_top[k]) begin
        found = 1'b1;
        idx   = REGION_IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (idx == '0) lower = base;
    else           lower = tops[idx - REGION_IDX_W'(1)];
    err = below_base || !found;
    if (err) begin
      sel    = '0;
      offset = '0;
    end else begin
      sel    = NUM_REGIONS'(1) << idx;
      offset = eff_addr - lower;
    end
  end
endmodule

// File: rtl/flash_region_decoder.sv
module flash_region_decoder
  import fdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic                   cfg_add_base,
  input  logic                   cfg_single_bus,
  input  logic [ADDR_W-1:0]      cfg_top_a1,
  input  logic [ADDR_W-1:0]      cfg_top_a2,
  input  logic [ADDR_W-1:0]      cfg_top_b1,
  input  logic [ADDR_W-1:0]      cfg_top_b2,
  output logic                   out_valid,
  output logic [NUM_REGIONS-1:0] out_sel,
  output logic                   out_bus,
  output logic                   out_cs,
  output logic [ADDR_W-1:0]      out_offset,
  output logic                   out_err
);
  logic [ADDR_W-1:0]       tops [NUM_REGIONS];
  logic [ADDR_W-1:0]       eff_addr;
  logic                    below_base;
  logic [NUM_REGIONS-1:0]  below_top;
  logic [NUM_REGIONS-1:0]  nxt_sel;
  logic [REGION_IDX_W-1:0] nxt_idx;
  logic                    nxt_err;
  logic [ADDR_W-1:0]       nxt_offset;
  fdec_bus_e               nxt_bus;

  assign tops[0] = cfg_top_a1;
  assign tops[1] = cfg_top_a2;
  assign tops[2] = cfg_top_b1;
  assign tops[3] = cfg_top_b2;

  fdec_addr_norm #(.ADDR_W(ADDR_W)) u_norm (
    .addr       (in_addr),
    .base       (cfg_base),
    .add_base   (cfg_add_base),
    .eff_addr   (eff_addr),
    .below_base (below_base)
  );

  fdec_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .eff_addr   (eff_addr),
    .tops       (tops),
    .single_bus (cfg_single_bus),
    .below_top  (below_top)
  );

  fdec_select #(.ADDR_W(ADDR_W)) u_sel (
    .eff_addr   (eff_addr),
    .base       (cfg_base),
    .tops       (tops),
    .below_top  (below_top),
    .below_base (below_base),
    .sel        (nxt_sel),
    .idx        (nxt_idx),
    .err        (nxt_err),
    .offset     (nxt_offset)
  );

  // Region index bit 1 names the bus, bit 0 the chip select on it.
  assign nxt_bus = nxt_idx[1] ? BUS_B : BUS_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sel    <= '0;
      out_bus    <= 1'b0;
      out_cs     <= 1'b0;
      out_offset <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sel    <= nxt_sel;
        out_bus    <= nxt_err ? 1'b0 : nxt_bus;
        out_cs     <= nxt_err ? 1'b0 : nxt_idx[0];
        out_offset <= nxt_offset;
        out_err    <= nxt_err;
      end
    end
  end

  // R3: at most one device selected.
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_sel));

  // R6: a flagged address drives no select.
  assert_err_no_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_sel == '0));

  // R2: strobe follows the request by exactly one cycle.
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R7: bus-B regions never chosen in single-bus mode.
  assert_single_bus_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_single_bus) |=> (out_sel[3:2] == 2'b00));

  // R8: result held while idle.
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sel) && $stable(out_offset) && $stable(out_err)));
endmodule

// File: tb/flash_region_decoder_test.sv
`timescale 1ns/1ps
module flash_region_decoder_test;
  localparam int AW = 12;
  localparam int SPAN = 1 << AW;
  localparam logic [AW-1:0] MASK = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [AW-1:0] cfg_base = '0;
  logic          cfg_add_base = 1'b0;
  logic          cfg_single_bus = 1'b0;
  logic [AW-1:0] top_a1 = '0, top_a2 = '0, top_b1 = '0, top_b2 = '0;
  logic          out_valid;
  logic [3:0]    out_sel;
  logic          out_bus, out_cs, out_err;
  logic [AW-1:0] out_offset;

  int compared = 0;
  int mismatched = 0;
  int fail_prints = 0;

  always #10 clk = ~clk; // 50 MHz

  flash_region_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_base(cfg_base), .cfg_add_base(cfg_add_base),
    .cfg_single_bus(cfg_single_bus),
    .cfg_top_a1(top_a1), .cfg_top_a2(top_a2),
    .cfg_top_b1(top_b1), .cfg_top_b2(top_b2),
    .out_valid(out_valid), .out_sel(out_sel), .out_bus(out_bus),
    .out_cs(out_cs), .out_offset(out_offset), .out_err(out_err)
  );

  task automatic note_fail(string req, string what, int act, int exp);
    mismatched++;
    if (fail_prints < 20) begin
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      fail_prints++;
    end
  endtask

  // Compare the whole registered result against one expectation.
  task automatic check_all(string req, logic v, logic [3:0] sel, logic bus,
                           logic cs, logic [AW-1:0] off, logic err);
    compared++;
    if (out_valid !== v)    note_fail(req, "valid",  int'(out_valid),  int'(v));
    else if (out_sel !== sel) note_fail(req, "sel",  int'(out_sel),    int'(sel));
    else if (out_bus !== bus) note_fail(req, "bus",  int'(out_bus),    int'(bus));
    else if (out_cs !== cs)   note_fail(req, "cs",   int'(out_cs),     int'(cs));
    else if (out_offset !== off) note_fail(req, "offset", int'(out_offset), int'(off));
    else if (out_err !== err) note_fail(req, "err",  int'(out_err),    int'(err));
  endtask

  // Present one request at a falling edge, check after the next rising edge.
  task automatic apply(logic [AW-1:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(posedge clk);
    #1;
  endtask

  // Equal split: region k spans base + k*size .. base + (k+1)*size.
  task automatic sweep_equal(string req, int base, int size, int nreg, logic addb);
    for (int a = 0; a < SPAN; a++) begin
      int eff;
      int k;
      string tag;
      eff = addb ? ((a + base) % SPAN) : a;
      apply(AW'(a));
      if (eff < base || eff >= base + nreg * size) begin
        tag = (nreg == 2 && eff >= base + 2 * size) ? "R7" : "R6";
        check_all(tag, 1'b1, 4'b0000, 1'b0, 1'b0, '0, 1'b1);
      end else begin
        k = (eff - base) / size;
        check_all(req, 1'b1, 4'(1 << k), k[1], k[0], AW'((eff - base) % size), 1'b0);
      end
    end
  endtask

  int wd_cycles = 0;
  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", wd_cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check_all("R1", 1'b0, 4'b0000, 1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1", 1'b0, 4'b0000, 1'b0, 1'b0, '0, 1'b0);

    // Equal split, base 0x100, region size 0x300.
    cfg_base = 12'h100;
    top_a1 = 12'h400; top_a2 = 12'h700; top_b1 = 12'hA00; top_b2 = 12'hD00;

    // R2: before the edge the result is not there yet; after it, it is.
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = 12'h705;
    #2;
    check_all("R2", 1'b0, 4'b0000, 1'b0, 1'b0, '0, 1'b0);
    @(posedge clk);
    #1;
    check_all("R2", 1'b1, 4'b0100, 1'b1, 1'b0, 12'h005, 1'b0);

    // R3 and R6: exhaustive sweep, address used as is.
    sweep_equal("R3", 'h100, 'h300, 4, 1'b0);

    // R5: base added inside, including wrap below the base.
    cfg_add_base = 1'b1;
    sweep_equal("R5", 'h100, 'h300, 4, 1'b1);
    cfg_add_base = 1'b0;

    // R7: single bus; bus-B tops cover everything and must be ignored.
    cfg_single_bus = 1'b1;
    top_b1 = 12'hFFF; top_b2 = 12'hFFF;
    sweep_equal("R7", 'h100, 'h300, 2, 1'b0);
    cfg_single_bus = 1'b0;

    // R4: uneven split with an empty A2 region.
    cfg_base = 12'h080;
    top_a1 = 12'h180; top_a2 = 12'h180; top_b1 = 12'h900; top_b2 = 12'hFF0;
    for (int a = 0; a < SPAN; a++) begin
      apply(AW'(a));
      if (a < 'h080 || a >= 'hFF0)
        check_all("R6", 1'b1, 4'b0000, 1'b0, 1'b0, '0, 1'b1);
      else if (a < 'h180)
        check_all("R4", 1'b1, 4'b0001, 1'b0, 1'b0, AW'(a - 'h080), 1'b0);
      else if (a < 'h900)
        check_all("R4", 1'b1, 4'b0100, 1'b1, 1'b0, AW'(a - 'h180), 1'b0);
      else
        check_all("R4", 1'b1, 4'b1000, 1'b1, 1'b1, AW'(a - 'h900), 1'b0);
    end

    // R8: idle cycles with a changed address leave the result untouched.
    apply(12'h905);
    check_all("R8", 1'b1, 4'b1000, 1'b1, 1'b1, 12'h005, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_addr  = AW'(12'h010 + i * 12'h123) & MASK;
      @(posedge clk);
      #1;
      check_all("R8", 1'b0, 4'b1000, 1'b1, 1'b1, 12'h005, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule